// File: doc/BRIEF.md
# DRAM refresh postponement scheduler

This block keeps the refresh books for one DRAM rank. A countdown timer, reloaded from the refresh interval of the active operating point, adds one owed refresh each time it expires. Each refresh the command arbiter grants while the block is requesting removes one owed refresh. Three ordered thresholds on the owed count decide when to ask for refresh. The normal threshold asks for refresh when a slot is free. The high threshold marks the request urgent, so the arbiter holds other traffic. In per-bank mode, a lower continuous threshold asks for back-to-back per-bank refreshes. A second countdown defines the refresh-period window, and a programmable cap limits how many refreshes are granted inside one window.

Two register sets (set 0 and set 1) each give a refresh interval and a window length in memory-clock cycles. When the clock changes operating point, the requester raises a frequency-change request that names the target set. The block freezes both countdowns and converts their remaining cycles to the new clock with an exact floor division. This keeps the window and postponement limits correct at any ratio, including 7:1 and above. It then switches sets and acknowledges the change. Thresholds and the cap are programmed before initialisation and are locked from then on.

Top module: `rfsh_sched`

## Requirements
- R1: A configuration write is applied only when the ordering holds. The rule is norm < high and cap >= 1; with per-bank mode on, also 1 <= cont < norm; with per-bank mode off, norm >= 1. Otherwise the write is discarded and `cfg_err` goes to 1. A valid write clears `cfg_err`. After reset `cfg_err` is 0 and the defaults are high=12, norm=4, cont=2, cap=8 and per-bank off.
- R2: Once `init_start` has been seen (`mission`=1), configuration writes change neither the thresholds nor `cfg_err`.
- R3: After reset `owed_cnt` is 0, `mission` is 0 and `ref_req` is 0. Counting from the clock edge that samples `init_start`, `owed_cnt` rises by one every T edges, where T is the refresh interval of the active set (first rise T edges after init).
- R4: A grant takes effect only in a cycle where `ref_req` is 1, and it lowers `owed_cnt` by one. A grant and a timer expiry in the same cycle leave the count unchanged. `owed_cnt` never exceeds high+1.
- R5: `ref_req` is 1 when `owed_cnt` >= norm (per-bank off) or >= cont (per-bank on), and the window cap has not been reached. `ref_high` is 1 when `ref_req` is 1 and `owed_cnt` >= high.
- R6: `ref_pb_cont` is 1 only when per-bank mode is on, `ref_req` is 1 and `owed_cnt` >= cont. With per-bank mode off, cont has no effect, whatever its value.
- R7: Within one window of W edges (W = window length of the active set, windows starting at init), at most cap grants take effect. `ref_req` is 0 while the cap is reached.
- R8: A frequency-change request is accepted only in an idle cycle with `ref_grant` at 0. From acceptance until the switch, `owed_cnt` holds and `fc_ack` stays 0.
- R9: On a change from set a to set b, each countdown's remaining value r is replaced by floor(r*Pb/Pa), where P is that countdown's period in the two sets. `act_sel` then becomes `fc_sel` (0 = set 0, 1 = set 1). The next owed increment comes floor(r*Tb/Ta)+1 edges after the switch, and each later one comes every Tb edges.
- R10: `fc_ack` is a one-cycle pulse. It is seen 34 edges after the accepting edge, counting that edge, with the default 16-bit counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for thresholds, cap and mode |
| cfg_high | input | 5 | Urgent threshold |
| cfg_norm | input | 5 | Normal threshold |
| cfg_cont | input | 5 | Continuous per-bank threshold |
| cfg_cap | input | 4 | Maximum grants per window |
| cfg_pb_en | input | 1 | Per-bank refresh mode |
| init_start | input | 1 | Starts the timers and locks configuration |
| trefi_set0 | input | 16 | Refresh interval in cycles, set 0 |
| trefi_set1 | input | 16 | Refresh interval in cycles, set 1 |
| window_set0 | input | 16 | Window length in cycles, set 0 |
| window_set1 | input | 16 | Window length in cycles, set 1 |
| fc_req | input | 1 | Frequency-change request |
| fc_sel | input | 1 | Target register set for the change |
| ref_grant | input | 1 | Arbiter grants a refresh slot |
| ref_req | output | 1 | Refresh requested |
| ref_high | output | 1 | Request is urgent; other traffic held |
| ref_pb_cont | output | 1 | Back-to-back per-bank refresh requested |
| owed_cnt | output | 6 | Owed refresh count |
| cfg_err | output | 1 | Last configuration write was rejected |
| mission | output | 1 | Initialisation done, configuration locked |
| fc_ack | output | 1 | Frequency change completed |
| act_sel | output | 1 | Active register set |

## Verification
An interval countdown that drifts by a single cycle shows up as `owed_cnt` changing one edge early or late. An error in the window counter shows as `ref_req` dropping at the wrong grant, or returning at the wrong window boundary; both appear within one interval or one window. A wrong rescale quotient shows only after the switch, as a wrong gap before the next owed increment. A wrong divider step count moves `fc_ack` off its fixed edge. The bench therefore times these gaps in both directions of change, on ratios of 8:1 and 1:8.

// File: rtl/rfsh_sched_pkg.sv
package rfsh_sched_pkg;

    parameter int TH_W  = 5;
    parameter int OW_W  = TH_W + 1;
    parameter int CAP_W = 4;
    parameter int CNT_W = 16;
    parameter int NSETS = 2;
    parameter int NCHAN = 2;   // channel 0: refresh interval, channel 1: window

    typedef logic [TH_W-1:0]  th_t;
    typedef logic [OW_W-1:0]  owed_t;
    typedef logic [CAP_W-1:0] cap_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        th_t  high;
        th_t  norm;
        th_t  cont;
        cap_t cap;
        logic pb_en;
    } thr_cfg_t;

    typedef enum logic [1:0] {
        FC_IDLE  = 2'd0,
        FC_SCALE = 2'd1,
        FC_ACK   = 2'd2
    } fc_state_t;

    function automatic logic cfg_valid(thr_cfg_t c);
        logic low_ok;
        if (c.pb_en)
            low_ok = (c.cont != '0) && (c.cont < c.norm);
        else
            low_ok = (c.norm != '0);
        return low_ok && (c.norm < c.high) && (c.cap != '0);
    endfunction

    function automatic owed_t owed_ceiling(thr_cfg_t c);
        return owed_t'({1'b0, c.high}) + owed_t'(1);
    endfunction

    function automatic th_t low_threshold(thr_cfg_t c);
        return c.pb_en ? c.cont : c.norm;
    endfunction

endpackage

// File: rtl/rfsh_cfg_lock.sv
module rfsh_cfg_lock
    import rfsh_sched_pkg::*;
#(
    parameter thr_cfg_t DEF_CFG = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  thr_cfg_t wr_cfg,
    input  logic     locked,
    output thr_cfg_t cfg_q,
    output logic     cfg_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= DEF_CFG;
            cfg_err <= 1'b0;
        end else if (wr_en && !locked) begin
            if (cfg_valid(wr_cfg)) begin
                cfg_q   <= wr_cfg;
                cfg_err <= 1'b0;
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end

    // R1: the applied configuration always respects the ordering
    a_r1_cfg_ordered: assert property (@(posedge clk) disable iff (rst)
        cfg_valid(cfg_q));

    // R2: nothing moves after the lock
    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        locked && $past(locked) |-> $stable(cfg_q) && $stable(cfg_err));

endmodule

// File: rtl/rfsh_countdown.sv
module rfsh_countdown
    import rfsh_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t load_val,
    input  logic run,
    input  cnt_t reload_val,
    output logic expire,
    output cnt_t value
);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (load)
            value <= load_val;
        else if (run)
            value <= (value == '0) ? reload_val : value - cnt_t'(1);
    end

    assign expire = run && !load && (value == '0);

    // R3: an expiry restarts the full period
    a_r3_reload_on_expire: assert property (@(posedge clk) disable iff (rst)
        expire |=> value == $past(reload_val));

endmodule

// File: rtl/rfsh_rescale.sv
module rfsh_rescale
    import rfsh_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cnt_t value,
    input  cnt_t num_period,
    input  cnt_t den_period,
    output logic done,
    output cnt_t result
);

    localparam int PW = 2 * CNT_W;
    localparam int SW = $clog2(PW + 1);

    logic [PW-1:0]  acc;
    logic [PW-1:0]  prod_r;
    logic [CNT_W:0] rem;
    logic [CNT_W:0] trial;
    cnt_t           den_r;
    logic [SW-1:0]  steps;
    logic           busy;
    logic           fits;

    always_comb begin
        trial = {rem[CNT_W-1:0], acc[PW-1]};
        fits  = trial >= {1'b0, den_r};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            prod_r <= '0;
            rem    <= '0;
            den_r  <= '0;
            steps  <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc    <= PW'(value) * PW'(num_period);
                prod_r <= PW'(value) * PW'(num_period);
                rem    <= '0;
                den_r  <= den_period;
                steps  <= SW'(PW);
                busy   <= 1'b1;
            end else if (busy) begin
                acc   <= {acc[PW-2:0], fits};
                rem   <= fits ? trial - {1'b0, den_r} : trial;
                steps <= steps - SW'(1);
                if (steps == SW'(1)) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    result <= {acc[CNT_W-2:0], fits};
                end
            end
        end
    end

    // R9: the quotient is the exact floor of product over old period
    a_r9_floor_low: assert property (@(posedge clk) disable iff (rst)
        done && den_r != '0 |-> PW'(result) * PW'(den_r) <= prod_r);
    a_r9_floor_tight: assert property (@(posedge clk) disable iff (rst)
        done && den_r != '0 |-> prod_r - PW'(result) * PW'(den_r) < PW'(den_r));

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_sched_pkg::*;
#(
    parameter int DEF_HIGH = 12,
    parameter int DEF_NORM = 4,
    parameter int DEF_CONT = 2,
    parameter int DEF_CAP  = 8,
    parameter int DEF_PB   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [TH_W-1:0]  cfg_high,
    input  logic [TH_W-1:0]  cfg_norm,
    input  logic [TH_W-1:0]  cfg_cont,
    input  logic [CAP_W-1:0] cfg_cap,
    input  logic             cfg_pb_en,
    input  logic             init_start,
    input  logic [CNT_W-1:0] trefi_set0,
    input  logic [CNT_W-1:0] trefi_set1,
    input  logic [CNT_W-1:0] window_set0,
    input  logic [CNT_W-1:0] window_set1,
    input  logic             fc_req,
    input  logic             fc_sel,
    input  logic             ref_grant,
    output logic             ref_req,
    output logic             ref_high,
    output logic             ref_pb_cont,
    output logic [OW_W-1:0]  owed_cnt,
    output logic             cfg_err,
    output logic             mission,
    output logic             fc_ack,
    output logic             act_sel
);

    localparam thr_cfg_t DEF_CFG = '{
        high:  th_t'(DEF_HIGH),
        norm:  th_t'(DEF_NORM),
        cont:  th_t'(DEF_CONT),
        cap:   cap_t'(DEF_CAP),
        pb_en: 1'(DEF_PB)
    };

    thr_cfg_t  wr_cfg;
    thr_cfg_t  cfg_q;
    fc_state_t st;
    logic      mission_q;
    logic      act_q;
    logic      tgt_q;
    owed_t     owed_q;
    cap_t      issued_q;

    cnt_t trefi_tab [NSETS];
    cnt_t win_tab   [NSETS];
    cnt_t per_cur   [NCHAN];
    cnt_t per_req   [NCHAN];
    cnt_t tval      [NCHAN];
    cnt_t sc_q      [NCHAN];
    cnt_t load_val  [NCHAN];
    logic [NCHAN-1:0] expire;
    logic [NCHAN-1:0] sc_done;

    logic fc_start;
    logic scale_load;
    logic init_load;
    logic cd_load;
    logic run_en;
    logic grant_ok;
    logic tick;
    logic win_end;

    // configuration capture and lock
    assign wr_cfg = '{high: cfg_high, norm: cfg_norm, cont: cfg_cont,
                      cap: cfg_cap, pb_en: cfg_pb_en};

    rfsh_cfg_lock #(.DEF_CFG(DEF_CFG)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_cfg  (wr_cfg),
        .locked  (mission_q),
        .cfg_q   (cfg_q),
        .cfg_err (cfg_err)
    );

    // per-frequency register sets
    assign trefi_tab[0] = trefi_set0;
    assign trefi_tab[1] = trefi_set1;
    assign win_tab[0]   = window_set0;
    assign win_tab[1]   = window_set1;

    assign per_cur[0] = trefi_tab[act_q];
    assign per_cur[1] = win_tab[act_q];
    assign per_req[0] = trefi_tab[fc_sel];
    assign per_req[1] = win_tab[fc_sel];

    // control
    assign fc_start   = (st == FC_IDLE) && fc_req && !ref_grant;
    assign scale_load = (st == FC_SCALE) && (&sc_done);
    assign init_load  = init_start && !mission_q;
    assign cd_load    = init_load || scale_load;
    assign run_en     = mission_q && (st != FC_SCALE) && !fc_start;

    // countdown and rescale channels
    for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
        assign load_val[ch] = scale_load ? sc_q[ch] : per_cur[ch] - cnt_t'(1);

        rfsh_countdown u_cd (
            .clk        (clk),
            .rst        (rst),
            .load       (cd_load),
            .load_val   (load_val[ch]),
            .run        (run_en),
            .reload_val (per_cur[ch] - cnt_t'(1)),
            .expire     (expire[ch]),
            .value      (tval[ch])
        );

        rfsh_rescale u_rs (
            .clk        (clk),
            .rst        (rst),
            .start      (fc_start),
            .value      (tval[ch]),
            .num_period (per_req[ch]),
            .den_period (per_cur[ch]),
            .done       (sc_done[ch]),
            .result     (sc_q[ch])
        );
    end

    assign tick    = expire[0];
    assign win_end = expire[1];

    // frequency-change sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FC_IDLE;
            act_q     <= 1'b0;
            tgt_q     <= 1'b0;
            mission_q <= 1'b0;
        end else begin
            if (init_load)
                mission_q <= 1'b1;
            unique case (st)
                FC_IDLE: begin
                    if (fc_start) begin
                        tgt_q <= fc_sel;
                        st    <= FC_SCALE;
                    end
                end
                FC_SCALE: begin
                    if (scale_load) begin
                        act_q <= tgt_q;
                        st    <= FC_ACK;
                    end
                end
                default: st <= FC_IDLE;
            endcase
        end
    end

    // request decisions
    always_comb begin
        ref_req = mission_q && (st != FC_SCALE)
                  && (owed_q >= owed_t'(low_threshold(cfg_q)))
                  && (issued_q < cfg_q.cap);
        ref_high    = ref_req && (owed_q >= owed_t'(cfg_q.high));
        ref_pb_cont = ref_req && cfg_q.pb_en && (owed_q >= owed_t'(cfg_q.cont));
    end

    assign grant_ok = ref_grant && ref_req;

    // owed refresh count and window usage
    always_ff @(posedge clk) begin
        if (rst) begin
            owed_q   <= '0;
            issued_q <= '0;
        end else begin
            if (tick && !grant_ok) begin
                if (owed_q < owed_ceiling(cfg_q))
                    owed_q <= owed_q + owed_t'(1);
            end else if (grant_ok && !tick) begin
                owed_q <= owed_q - owed_t'(1);
            end
            if (win_end)
                issued_q <= grant_ok ? cap_t'(1) : '0;
            else if (grant_ok)
                issued_q <= issued_q + cap_t'(1);
        end
    end

    assign owed_cnt = owed_q;
    assign mission  = mission_q;
    assign fc_ack   = (st == FC_ACK);
    assign act_sel  = act_q;

    // R4: owed count bounded and moves by at most one per cycle
    a_r4_owed_ceiling: assert property (@(posedge clk) disable iff (rst)
        owed_q <= owed_ceiling(cfg_q));
    a_r4_owed_step: assert property (@(posedge clk) disable iff (rst)
        mission_q |=> (owed_q == $past(owed_q)) ||
                      (owed_q == $past(owed_q) + owed_t'(1)) ||
                      (owed_q + owed_t'(1) == $past(owed_q)));
    // R7: window usage never passes the cap
    a_r7_cap_held: assert property (@(posedge clk) disable iff (rst)
        issued_q <= cfg_q.cap);
    // R8: no acceptance while a grant is present, owed frozen while scaling
    a_r8_no_accept_on_grant: assert property (@(posedge clk) disable iff (rst)
        st == FC_IDLE && ref_grant |=> st != FC_SCALE);
    a_r8_owed_frozen: assert property (@(posedge clk) disable iff (rst)
        st == FC_SCALE |=> owed_q == $past(owed_q));
    // R10: acknowledge lasts one cycle
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        fc_ack |=> !fc_ack);

endmodule

// File: tb/rfsh_sched_bench.sv
module rfsh_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_high = '0, cfg_norm = '0, cfg_cont = '0;
    logic [3:0]  cfg_cap = '0;
    logic        cfg_pb_en = 1'b0;
    logic        init_start = 1'b0;
    logic [15:0] trefi_set0 = 16'd40, trefi_set1 = 16'd5;
    logic [15:0] window_set0 = 16'd320, window_set1 = 16'd40;
    logic        fc_req = 1'b0, fc_sel = 1'b0, ref_grant = 1'b0;
    logic        ref_req, ref_high, ref_pb_cont, cfg_err, mission, fc_ack, act_sel;
    logic [5:0]  owed_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int m_k, m_owed, m_iss, m_trefi, m_win, m_high, m_norm, m_cont, m_cap;
    bit m_pb;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfsh_sched u_rfsh_sched (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_high(cfg_high),
        .cfg_norm(cfg_norm), .cfg_cont(cfg_cont), .cfg_cap(cfg_cap),
        .cfg_pb_en(cfg_pb_en), .init_start(init_start),
        .trefi_set0(trefi_set0), .trefi_set1(trefi_set1),
        .window_set0(window_set0), .window_set1(window_set1),
        .fc_req(fc_req), .fc_sel(fc_sel), .ref_grant(ref_grant),
        .ref_req(ref_req), .ref_high(ref_high), .ref_pb_cont(ref_pb_cont),
        .owed_cnt(owed_cnt), .cfg_err(cfg_err), .mission(mission),
        .fc_ack(fc_ack), .act_sel(act_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_wr = 0; init_start = 0; fc_req = 0; fc_sel = 0; ref_grant = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_high = 12; m_norm = 4; m_cont = 2; m_cap = 8; m_pb = 0;
    endtask

    task automatic write_cfg(input int h, input int n, input int c, input int cap, input bit pb);
        @(negedge clk);
        cfg_wr = 1; cfg_high = 5'(h); cfg_norm = 5'(n); cfg_cont = 5'(c);
        cfg_cap = 4'(cap); cfg_pb_en = pb;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic do_init();
        @(negedge clk);
        init_start = 1;
        @(posedge clk);
        @(negedge clk);
        init_start = 0;
        m_k = 0; m_owed = 0; m_iss = 0;
    endtask

    function automatic bit model_req();
        return (m_owed >= (m_pb ? m_cont : m_norm)) && (m_iss < m_cap);
    endfunction

    task automatic run_model(input int n, input bit g, input string t_owed, input string t_req);
        ref_grant = g;
        for (int i = 0; i < n; i++) begin
            bit req_pre, acc, tick, wend;
            req_pre = model_req();
            @(posedge clk);
            m_k++;
            tick = (m_k % m_trefi) == 0;
            wend = (m_k % m_win) == 0;
            acc  = g && req_pre;
            if (tick && !acc) begin
                if (m_owed < m_high + 1) m_owed++;
            end else if (acc && !tick) begin
                m_owed--;
            end
            if (wend) m_iss = acc ? 1 : 0;
            else if (acc) m_iss++;
            @(negedge clk);
            chk(t_owed, int'(owed_cnt), m_owed);
            chk(t_req, int'(ref_req), int'(model_req()));
            chk("R5 high", int'(ref_high), int'(model_req() && m_owed >= m_high));
            chk("R6 pbcont", int'(ref_pb_cont), int'(model_req() && m_pb && m_owed >= m_cont));
        end
        ref_grant = 0;
    endtask

    // waits for the acknowledge, returns edges counted from the accepting edge
    task automatic wait_ack(output int n, input int hold);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (fc_ack) begin
                fc_req = 0;
                break;
            end
            chk("R8 owed held", int'(owed_cnt), hold);
        end
    endtask

    task automatic edges_to_change(output int e, input int from);
        e = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            e++;
            @(negedge clk);
            if (e == 1) chk("R10 ack low", int'(fc_ack), 0);
            if (int'(owed_cnt) != from) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n, e, t_old;
        m_trefi = 40; m_win = 320;
        do_reset();
        chk("R3 reset owed", int'(owed_cnt), 0);
        chk("R3 reset req", int'(ref_req), 0);
        chk("R3 reset mission", int'(mission), 0);
        chk("R1 reset err", int'(cfg_err), 0);
        chk("R10 reset ack", int'(fc_ack), 0);

        // configuration ordering
        write_cfg(6, 3, 2, 2, 0);
        chk("R1 valid", int'(cfg_err), 0);
        write_cfg(3, 5, 2, 2, 0);
        chk("R1 norm>=high", int'(cfg_err), 1);
        write_cfg(6, 3, 3, 2, 1);
        chk("R1 cont>=norm", int'(cfg_err), 1);
        write_cfg(6, 3, 2, 0, 0);
        chk("R1 cap zero", int'(cfg_err), 1);
        m_high = 6; m_norm = 3; m_cont = 2; m_cap = 2; m_pb = 0;
        do_init();
        chk("R3 mission", int'(mission), 1);
        write_cfg(2, 1, 0, 8, 0);
        m_k = 2;
        chk("R2 err locked", int'(cfg_err), 1);
        run_model(328, 0, "R3 owed", "R2 req");
        chk("R4 saturation", int'(owed_cnt), 7);
        run_model(700, 1, "R4 owed", "R7 req");

        // per-bank mode
        do_reset();
        m_trefi = 12; trefi_set0 = 16'd12;
        write_cfg(6, 4, 2, 8, 1);
        chk("R1 pb valid", int'(cfg_err), 0);
        m_high = 6; m_norm = 4; m_cont = 2; m_cap = 8; m_pb = 1;
        do_init();
        run_model(150, 0, "R3 owed pb", "R6 req");
        run_model(120, 1, "R4 owed pb", "R6 req g");

        // per-bank off: cont above norm is ignored
        do_reset();
        write_cfg(6, 3, 9, 8, 0);
        chk("R6 cont ignored cfg", int'(cfg_err), 0);
        m_high = 6; m_norm = 3; m_cont = 9; m_cap = 8; m_pb = 0;
        do_init();
        run_model(100, 0, "R3 owed", "R6 req off");

        // frequency change down (8:1) and back up
        do_reset();
        trefi_set0 = 16'd40; m_trefi = 40;
        do_init();
        run_model(50, 0, "R3 owed", "R5 req");
        fc_req = 1; fc_sel = 1; ref_grant = 1;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R8 blocked by grant", int'(fc_ack), 0);
        end
        chk("R8 owed before", int'(owed_cnt), 2);
        ref_grant = 0;
        t_old = (40 - 1) - (90 % 40);
        wait_ack(n, 2);
        chk("R10 ack latency", n, 2 * CW + 2);
        chk("R9 set switched", int'(act_sel), 1);
        edges_to_change(e, 2);
        chk("R9 first gap down", e, (t_old * 5) / 40 + 1);
        edges_to_change(e, 3);
        chk("R9 period down", e, 5);
        fc_req = 1; fc_sel = 0;
        wait_ack(n, 4);
        chk("R10 ack latency up", n, 2 * CW + 2);
        chk("R9 set back", int'(act_sel), 0);
        edges_to_change(e, 4);
        chk("R9 first gap up", e, (4 * 40) / 5 + 1);
        chk("R9 owed after", int'(owed_cnt), 5);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule